// File: doc/BRIEF.md
# DMA Manager Security Gate

This block sits between the register bus and the manager thread of a DMA engine. It vets the two instructions a manager may issue, channel-start and send-event, against the manager's security mode. It also checks the security attributes of the target: the security flag requested for a new channel, or the configured security of an event line. For each instruction it either carries out the action or puts the manager into a latched abort state that records a fault code.

A secure manager may start channels in either security state and may signal any event. A non-secure manager may only start non-secure channels and signal events configured as non-secure. The block keeps a running bit and a security status bit for each channel. A channel's completion input clears its running bit, so the channel can be started again. While the manager is aborted, every issued instruction is dropped until software pulses the clear input.

Instruction encoding: byte 0 is the opcode. Channel-start is any byte that equals 0xA0 once bit 1 is masked off, and bit 1 is the requested non-secure flag. Send-event is 0x34. For channel-start, byte 1 bits [2:0] select the channel. For send-event, byte 1 bits [7:3] select the event.

Top module: `dmamgr_sec_gate`

## Requirements
- R1: After synchronous reset, start_vld_o, start_ns_o, abort_o, every bit of chan_run_o, chan_ns_o and evt_pulse_o, and fault_o are all 0.
- R2: With mgr_ns_i=0, channel-start with opcode 0xA0 (bit 1 = 0) on byte 1 bits [2:0] = c gives, in the cycle after issue_i, start_vld_o=1, start_chan_o=c and start_ns_o=0. It also sets chan_ns_o[c]=0 and chan_run_o[c]=1.
- R3: With mgr_ns_i=0, channel-start with opcode 0xA2 (bit 1 = 1) starts channel c non-secure: start_ns_o=1, chan_ns_o[c]=1, chan_run_o[c]=1.
- R4: With mgr_ns_i=0, send-event (0x34) with byte 1 bits [7:3] = e pulses evt_pulse_o[e] for one cycle, whatever evt_ns_cfg_i[e] is.
- R5: With mgr_ns_i=1, channel-start with bit 1 = 0 produces no start pulse and leaves the channel's run and status bits unchanged. It sets abort_o with fault_o=1.
- R6: With mgr_ns_i=1, channel-start with bit 1 = 1 starts the channel non-secure, as in R3.
- R7: With mgr_ns_i=1, send-event to an event with evt_ns_cfg_i[e]=0 sets abort_o with fault_o=2. When evt_ns_cfg_i[e]=1, it pulses evt_pulse_o[e].
- R8: Each accepted instruction produces exactly one of these, for exactly one cycle: a start pulse, a single event pulse, or the rise of abort_o.
- R9: abort_o and fault_o hold until abort_clr_i is pulsed, which returns both to 0. Instructions issued while abort_o=1 have no effect on any output.
- R10: Channel-start to a channel whose chan_run_o bit is 1 sets abort_o with fault_o=3 and leaves that channel's run and status bits unchanged.
- R11: An unrecognized opcode, or send-event naming an event index of NUM_EVT or more, sets abort_o with fault_o=4.
- R12: A pulse on chan_done_i[c] clears chan_run_o[c] on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mgr_ns_i | input | 1 | Manager security mode, 1 = non-secure |
| issue_i | input | 1 | Instruction issue strobe |
| insn_b0_i | input | 8 | Instruction byte 0 (opcode) |
| insn_b1_i | input | 8 | Instruction byte 1 (channel or event operand) |
| evt_ns_cfg_i | input | NUM_EVT | Per-event security, 1 = non-secure |
| chan_done_i | input | NUM_CHAN | Per-channel completion pulse |
| abort_clr_i | input | 1 | Clears the abort state |
| start_vld_o | output | 1 | One-cycle channel start request |
| start_chan_o | output | CH_W | Channel being started |
| start_ns_o | output | 1 | Security state of the started channel |
| chan_run_o | output | NUM_CHAN | Per-channel running bit |
| chan_ns_o | output | NUM_CHAN | Per-channel security status, 1 = non-secure |
| evt_pulse_o | output | NUM_EVT | One-cycle event pulses |
| abort_o | output | 1 | Manager abort flag |
| fault_o | output | 3 | Fault code while aborted |

## Verification
Several properties are checked on every cycle. At most one kind of result appears at a time, and event pulses are one-hot. A started channel's status bit matches its start flag and the channel was idle before the start. A non-secure manager never starts a secure channel or pulses a secure event. The abort state and its code hold until cleared, and nothing fires while aborted. Only the bench scenarios can show the rest: that each opcode, operand and security pairing produces the specific channel, event or fault code required, that ignored instructions leave channel state untouched, and that completion makes a channel startable again.

// File: rtl/dsg_pkg.sv
package dsg_pkg;

    localparam logic [7:0] OPC_START_BASE = 8'hA0;
    localparam logic [7:0] OPC_START_MASK = 8'hFD;
    localparam logic [7:0] OPC_SEND_EVT   = 8'h34;
    localparam int         NS_FLAG_BIT    = 1;

    typedef enum logic [2:0] {
        FLT_NONE      = 3'd0,
        FLT_CHAN_SEC  = 3'd1,
        FLT_EVT_SEC   = 3'd2,
        FLT_CHAN_BUSY = 3'd3,
        FLT_BAD_INSN  = 3'd4
    } fault_e;

    typedef enum logic [1:0] {
        INS_NONE  = 2'd0,
        INS_START = 2'd1,
        INS_SEV   = 2'd2,
        INS_BAD   = 2'd3
    } ins_kind_e;

    typedef struct packed {
        ins_kind_e  kind;
        logic       req_ns;
        logic [7:0] chan;
        logic [7:0] evt;
    } decoded_t;

    typedef struct packed {
        logic   go_start;
        logic   go_evt;
        logic   go_abort;
        fault_e code;
    } verdict_t;

    function automatic logic is_start_op(input logic [7:0] op);
        return (op & OPC_START_MASK) == OPC_START_BASE;
    endfunction

    function automatic logic is_sev_op(input logic [7:0] op);
        return op == OPC_SEND_EVT;
    endfunction

endpackage

// File: rtl/dsg_decode.sv
module dsg_decode
    import dsg_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int NUM_EVT  = 16
) (
    input  logic       valid_i,
    input  logic [7:0] b0_i,
    input  logic [7:0] b1_i,
    output decoded_t   dec_o
);
    localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

    logic [7:0] chan_idx;
    logic [7:0] evt_idx;

    always_comb begin
        chan_idx = 8'(b1_i[CH_W-1:0]);
        evt_idx  = {3'b000, b1_i[7:3]};
        dec_o    = '{kind: INS_NONE, req_ns: 1'b0, chan: chan_idx, evt: evt_idx};
        if (valid_i) begin
            if (is_start_op(b0_i)) begin
                dec_o.req_ns = b0_i[NS_FLAG_BIT];
                dec_o.kind   = (chan_idx < 8'(NUM_CHAN)) ? INS_START : INS_BAD;
            end else if (is_sev_op(b0_i)) begin
                dec_o.kind = (evt_idx < 8'(NUM_EVT)) ? INS_SEV : INS_BAD;
            end else begin
                dec_o.kind = INS_BAD;
            end
        end
    end

endmodule

// File: rtl/dsg_policy.sv
module dsg_policy
    import dsg_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int NUM_EVT  = 16
) (
    input  logic                mgr_ns_i,
    input  decoded_t            dec_i,
    input  logic [NUM_EVT-1:0]  evt_ns_cfg_i,
    input  logic [NUM_CHAN-1:0] chan_run_i,
    output verdict_t            verdict_o
);
    localparam int CH_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam int EV_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;

    logic chan_busy;
    logic evt_is_ns;

    always_comb begin
        chan_busy = chan_run_i[dec_i.chan[CH_W-1:0]];
        evt_is_ns = evt_ns_cfg_i[dec_i.evt[EV_W-1:0]];
        verdict_o = '{go_start: 1'b0, go_evt: 1'b0, go_abort: 1'b0, code: FLT_NONE};
        unique case (dec_i.kind)
            INS_START: begin
                if (mgr_ns_i && !dec_i.req_ns) begin
                    verdict_o.go_abort = 1'b1;
                    verdict_o.code     = FLT_CHAN_SEC;
                end else if (chan_busy) begin
                    verdict_o.go_abort = 1'b1;
                    verdict_o.code     = FLT_CHAN_BUSY;
                end else begin
                    verdict_o.go_start = 1'b1;
                end
            end
            INS_SEV: begin
                if (mgr_ns_i && !evt_is_ns) begin
                    verdict_o.go_abort = 1'b1;
                    verdict_o.code     = FLT_EVT_SEC;
                end else begin
                    verdict_o.go_evt = 1'b1;
                end
            end
            INS_BAD: begin
                verdict_o.go_abort = 1'b1;
                verdict_o.code     = FLT_BAD_INSN;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dsg_chan_table.sv
module dsg_chan_table #(
    parameter int NUM_CHAN = 8,
    parameter int CH_W     = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start_en_i,
    input  logic [CH_W-1:0]     start_chan_i,
    input  logic                start_ns_i,
    input  logic [NUM_CHAN-1:0] done_i,
    output logic [NUM_CHAN-1:0] run_o,
    output logic [NUM_CHAN-1:0] ns_o
);
    for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
        logic hit;
        assign hit = start_en_i && (start_chan_i == CH_W'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                run_o[c] <= 1'b0;
                ns_o[c]  <= 1'b0;
            end else if (hit) begin
                run_o[c] <= 1'b1;
                ns_o[c]  <= start_ns_i;
            end else if (done_i[c]) begin
                run_o[c] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dmamgr_sec_gate.sv
module dmamgr_sec_gate
    import dsg_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int NUM_EVT  = 16,
    localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1,
    localparam int EV_W    = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mgr_ns_i,
    input  logic                issue_i,
    input  logic [7:0]          insn_b0_i,
    input  logic [7:0]          insn_b1_i,
    input  logic [NUM_EVT-1:0]  evt_ns_cfg_i,
    input  logic [NUM_CHAN-1:0] chan_done_i,
    input  logic                abort_clr_i,
    output logic                start_vld_o,
    output logic [CH_W-1:0]     start_chan_o,
    output logic                start_ns_o,
    output logic [NUM_CHAN-1:0] chan_run_o,
    output logic [NUM_CHAN-1:0] chan_ns_o,
    output logic [NUM_EVT-1:0]  evt_pulse_o,
    output logic                abort_o,
    output logic [2:0]          fault_o
);
    decoded_t           dec;
    verdict_t           verdict;
    logic               accept;
    logic [NUM_EVT-1:0] evt_hot;
    fault_e             fault_q;

    // Instructions are dropped while aborted or while a clear is in progress.
    assign accept = issue_i && !abort_o && !abort_clr_i;

    dsg_decode #(.NUM_CHAN(NUM_CHAN), .NUM_EVT(NUM_EVT)) u_decode (
        .valid_i (accept),
        .b0_i    (insn_b0_i),
        .b1_i    (insn_b1_i),
        .dec_o   (dec)
    );

    dsg_policy #(.NUM_CHAN(NUM_CHAN), .NUM_EVT(NUM_EVT)) u_policy (
        .mgr_ns_i     (mgr_ns_i),
        .dec_i        (dec),
        .evt_ns_cfg_i (evt_ns_cfg_i),
        .chan_run_i   (chan_run_o),
        .verdict_o    (verdict)
    );

    dsg_chan_table #(.NUM_CHAN(NUM_CHAN), .CH_W(CH_W)) u_chan_table (
        .clk          (clk),
        .rst          (rst),
        .start_en_i   (verdict.go_start),
        .start_chan_i (dec.chan[CH_W-1:0]),
        .start_ns_i   (dec.req_ns),
        .done_i       (chan_done_i),
        .run_o        (chan_run_o),
        .ns_o         (chan_ns_o)
    );

    always_comb begin
        evt_hot = '0;
        if (verdict.go_evt) evt_hot[dec.evt[EV_W-1:0]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            start_vld_o  <= 1'b0;
            start_chan_o <= '0;
            start_ns_o   <= 1'b0;
            evt_pulse_o  <= '0;
        end else begin
            start_vld_o <= verdict.go_start;
            evt_pulse_o <= evt_hot;
            if (verdict.go_start) begin
                start_chan_o <= dec.chan[CH_W-1:0];
                start_ns_o   <= dec.req_ns;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            abort_o <= 1'b0;
            fault_q <= FLT_NONE;
        end else if (abort_clr_i) begin
            abort_o <= 1'b0;
            fault_q <= FLT_NONE;
        end else if (verdict.go_abort) begin
            abort_o <= 1'b1;
            fault_q <= verdict.code;
        end
    end

    assign fault_o = fault_q;

endmodule

// File: rtl/dsg_sva.sv
module dsg_sva #(
    parameter int NUM_CHAN = 8,
    parameter int NUM_EVT  = 16,
    localparam int CH_W    = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
    input logic                clk,
    input logic                rst,
    input logic                mgr_ns_i,
    input logic [NUM_EVT-1:0]  evt_ns_cfg_i,
    input logic                abort_clr_i,
    input logic                start_vld_o,
    input logic [CH_W-1:0]     start_chan_o,
    input logic                start_ns_o,
    input logic [NUM_CHAN-1:0] chan_run_o,
    input logic [NUM_CHAN-1:0] chan_ns_o,
    input logic [NUM_EVT-1:0]  evt_pulse_o,
    input logic                abort_o,
    input logic [2:0]          fault_o
);
    logic [NUM_CHAN-1:0] run_prev;
    logic                abort_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_prev   <= '0;
            abort_prev <= 1'b0;
        end else begin
            run_prev   <= chan_run_o;
            abort_prev <= abort_o;
        end
    end

    // R8: one kind of result per cycle
    p_one_result_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({start_vld_o, (|evt_pulse_o), (abort_o && !abort_prev)}));

    p_evt_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_pulse_o));

    // R2 / R3: status of a freshly started channel follows its start flag
    p_start_status_r2: assert property (@(posedge clk) disable iff (rst)
        start_vld_o |-> (chan_run_o[start_chan_o] && (chan_ns_o[start_chan_o] == start_ns_o)));

    // R5: a non-secure manager never produces a secure start
    p_ns_mgr_start_r5: assert property (@(posedge clk) disable iff (rst)
        (start_vld_o && $past(mgr_ns_i)) |-> start_ns_o);

    // R7: a non-secure manager never pulses a secure event
    p_ns_mgr_evt_r7: assert property (@(posedge clk) disable iff (rst)
        ((|evt_pulse_o) && $past(mgr_ns_i)) |-> ((evt_pulse_o & ~$past(evt_ns_cfg_i)) == '0));

    // R9: abort state holds until cleared, and carries a code
    p_abort_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (abort_o && !abort_clr_i) |=> (abort_o && $stable(fault_o)));

    p_abort_code_r9: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> (fault_o != 3'd0));

    p_abort_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> (!start_vld_o && (evt_pulse_o == '0)));

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        abort_clr_i |=> (!abort_o && (fault_o == 3'd0)));

    // R10: a start only goes to a channel that was idle
    p_start_idle_r10: assert property (@(posedge clk) disable iff (rst)
        start_vld_o |-> !run_prev[start_chan_o]);

endmodule

bind dmamgr_sec_gate dsg_sva #(.NUM_CHAN(NUM_CHAN), .NUM_EVT(NUM_EVT)) u_sva (.*);

// File: tb/dmamgr_sec_gate_tb.sv
module dmamgr_sec_gate_tb_top;

    localparam int NUM_CHAN = 8;
    localparam int NUM_EVT  = 16;
    localparam int CH_W     = 3;

    localparam logic [1:0] K_ST = 2'd0;
    localparam logic [1:0] K_EV = 2'd1;
    localparam logic [1:0] K_AB = 2'd2;

    typedef struct packed {
        logic        mns;
        logic [7:0]  b0;
        logic [7:0]  b1;
        logic [15:0] cfg;
        logic [1:0]  kind;
        logic        ens;
        logic [7:0]  idx;
        logic [2:0]  flt;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VEC [NV] = '{
        '{1'b0, 8'hA0, 8'h02, 16'h0000, K_ST, 1'b0, 8'd2,  3'd0},
        '{1'b0, 8'hA2, 8'h05, 16'h0000, K_ST, 1'b1, 8'd5,  3'd0},
        '{1'b0, 8'hA2, 8'hFB, 16'h0000, K_ST, 1'b1, 8'd3,  3'd0},
        '{1'b0, 8'h34, 8'h18, 16'h0000, K_EV, 1'b0, 8'd3,  3'd0},
        '{1'b0, 8'h34, 8'h78, 16'h0000, K_EV, 1'b0, 8'd15, 3'd0},
        '{1'b1, 8'hA0, 8'h01, 16'hFFFF, K_AB, 1'b0, 8'd1,  3'd1},
        '{1'b1, 8'hA2, 8'h07, 16'h0000, K_ST, 1'b1, 8'd7,  3'd0},
        '{1'b1, 8'h34, 8'h20, 16'hFFEF, K_AB, 1'b0, 8'd4,  3'd2},
        '{1'b1, 8'h34, 8'h20, 16'h0010, K_EV, 1'b0, 8'd4,  3'd0},
        '{1'b0, 8'h55, 8'h00, 16'h0000, K_AB, 1'b0, 8'd0,  3'd4},
        '{1'b0, 8'h34, 8'hA0, 16'h0000, K_AB, 1'b0, 8'd0,  3'd4}
    };

    logic                clk = 1'b0;
    logic                rst;
    logic                mgr_ns_i;
    logic                issue_i;
    logic [7:0]          insn_b0_i;
    logic [7:0]          insn_b1_i;
    logic [NUM_EVT-1:0]  evt_ns_cfg_i;
    logic [NUM_CHAN-1:0] chan_done_i;
    logic                abort_clr_i;
    logic                start_vld_o;
    logic [CH_W-1:0]     start_chan_o;
    logic                start_ns_o;
    logic [NUM_CHAN-1:0] chan_run_o;
    logic [NUM_CHAN-1:0] chan_ns_o;
    logic [NUM_EVT-1:0]  evt_pulse_o;
    logic                abort_o;
    logic [2:0]          fault_o;

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dmamgr_sec_gate #(.NUM_CHAN(NUM_CHAN), .NUM_EVT(NUM_EVT)) dut_i (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one instruction; returns at the negedge where its result is visible.
    task automatic issue(input logic mns, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [15:0] cfg);
        @(negedge clk);
        mgr_ns_i     = mns;
        insn_b0_i    = b0;
        insn_b1_i    = b1;
        evt_ns_cfg_i = cfg;
        issue_i      = 1'b1;
        @(negedge clk);
        issue_i = 1'b0;
    endtask

    task automatic cleanup();
        abort_clr_i = 1'b1;
        chan_done_i = '1;
        @(negedge clk);
        abort_clr_i = 1'b0;
        chan_done_i = '0;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.kind == K_ST) return v.mns ? "R6" : (v.ens ? "R3" : "R2");
        if (v.kind == K_EV) return v.mns ? "R7" : "R4";
        if (v.flt == 3'd1) return "R5";
        if (v.flt == 3'd2) return "R7";
        return "R11";
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mgr_ns_i = 1'b0; issue_i = 1'b0; insn_b0_i = '0; insn_b1_i = '0;
        evt_ns_cfg_i = '0; chan_done_i = '0; abort_clr_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk({start_vld_o, start_ns_o, abort_o, fault_o, chan_run_o, chan_ns_o, evt_pulse_o} == '0,
            "R1", "reset outputs", 32'(abort_o), 32'h0);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            vec_t  v;
            string t;
            logic [NUM_EVT-1:0] eh;
            bit ok;
            v  = VEC[i];
            t  = tag_of(v);
            eh = '0;
            issue(v.mns, v.b0, v.b1, v.cfg);
            if (v.kind == K_ST) begin
                ok = start_vld_o && (32'(start_chan_o) == 32'(v.idx)) && (start_ns_o == v.ens)
                     && (chan_ns_o[v.idx[2:0]] == v.ens) && chan_run_o[v.idx[2:0]]
                     && (evt_pulse_o == '0) && !abort_o;
                chk(ok, t, $sformatf("vec%0d start", i),
                    {16'(start_chan_o), 7'd0, start_vld_o, 7'd0, start_ns_o},
                    {16'(v.idx), 8'd1, 7'd0, v.ens});
            end else if (v.kind == K_EV) begin
                eh[v.idx[3:0]] = 1'b1;
                ok = (evt_pulse_o == eh) && !start_vld_o && !abort_o;
                chk(ok, t, $sformatf("vec%0d event", i), 32'(evt_pulse_o), 32'(eh));
            end else begin
                ok = abort_o && (fault_o == v.flt) && !start_vld_o && (evt_pulse_o == '0);
                if (v.flt == 3'd1)
                    ok = ok && !chan_run_o[v.idx[2:0]] && !chan_ns_o[v.idx[2:0]];
                chk(ok, t, $sformatf("vec%0d abort", i),
                    {28'(abort_o), 1'b0, fault_o}, {28'd1, 1'b0, v.flt});
            end
            cleanup();
        end

        // R8 pulses last one cycle
        issue(1'b0, 8'hA2, 8'h06, 16'h0);
        @(negedge clk);
        chk(!start_vld_o && chan_run_o[6], "R8", "start pulse width", 32'(start_vld_o), 32'h0);
        issue(1'b0, 8'h34, 8'h08, 16'h0);
        @(negedge clk);
        chk(evt_pulse_o == '0, "R8", "event pulse width", 32'(evt_pulse_o), 32'h0);
        cleanup();

        // R10 start on running channel
        issue(1'b0, 8'hA2, 8'h00, 16'h0);
        issue(1'b0, 8'hA0, 8'h00, 16'h0);
        chk(abort_o && fault_o == 3'd3 && !start_vld_o, "R10", "busy abort",
            {28'(abort_o), 1'b0, fault_o}, {28'd1, 4'd3});
        chk(chan_run_o[0] && chan_ns_o[0], "R10", "busy channel unchanged",
            {30'd0, chan_run_o[0], chan_ns_o[0]}, 32'd3);
        abort_clr_i = 1'b1;
        @(negedge clk);
        abort_clr_i = 1'b0;

        // R12 completion clears run bit, channel restartable
        chan_done_i = 8'h01;
        @(negedge clk);
        chan_done_i = '0;
        chk(!chan_run_o[0], "R12", "done clears run", 32'(chan_run_o), 32'h0);
        issue(1'b0, 8'hA0, 8'h00, 16'h0);
        chk(start_vld_o && !abort_o && !chan_ns_o[0], "R12", "restart after done",
            {30'd0, start_vld_o, abort_o}, 32'd2);
        cleanup();

        // R9 latched abort, issues ignored, clear
        issue(1'b1, 8'hA0, 8'h02, 16'h0);
        chk(abort_o && fault_o == 3'd1, "R5", "ns manager secure start",
            32'(fault_o), 32'd1);
        issue(1'b0, 8'hA2, 8'h04, 16'h0);
        chk(!start_vld_o && !chan_run_o[4] && !chan_ns_o[4], "R9", "start ignored while aborted",
            {30'd0, start_vld_o, chan_run_o[4]}, 32'd0);
        issue(1'b0, 8'h34, 8'h10, 16'h0);
        chk(evt_pulse_o == '0, "R9", "event ignored while aborted", 32'(evt_pulse_o), 32'h0);
        repeat (3) @(negedge clk);
        chk(abort_o && fault_o == 3'd1, "R9", "abort held", {28'(abort_o), 1'b0, fault_o},
            {28'd1, 4'd1});
        abort_clr_i = 1'b1;
        @(negedge clk);
        abort_clr_i = 1'b0;
        chk(!abort_o && fault_o == 3'd0, "R9", "clear", {28'(abort_o), 1'b0, fault_o}, 32'd0);
        issue(1'b0, 8'hA2, 8'h04, 16'h0);
        chk(start_vld_o && chan_run_o[4] && chan_ns_o[4], "R9", "start accepted after clear",
            32'(start_vld_o), 32'd1);

        // R4 secure manager ignores event security configuration
        issue(1'b0, 8'h34, 8'h48, 16'hFFFF);
        chk(evt_pulse_o == 16'h0200, "R4", "secure mgr event with ns cfg",
            32'(evt_pulse_o), 32'h0200);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule